// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Access Protection

This block holds a small set of recent page translations and answers a lookup within the same cycle. Each lookup carries a virtual address, an address-space identifier and a read/write flag. The virtual page number and the identifier are compared with every stored entry in parallel. When one entry matches, the block joins that entry's physical frame number to the untouched low bits of the address to form the physical address. It also checks whether the access is allowed. At the next clock edge it records that the page was used and, for a permitted write, that the page was modified.

When nothing matches, the block raises a miss, and an outside table walker or trap handler refills one entry through the refill port. The refill port names the slot to overwrite. A flush input drops every translation at once, for example on a switch of address space.

Top module: `xlat_buffer`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports miss and never hit, with a physical address of zero.
- R2: `hit` is high only when `lk_valid` is high and some valid entry has both a virtual page number equal to `lk_vaddr[VA_W-1:12]` and an identifier equal to `lk_asid`. `miss` is high when `lk_valid` is high and no entry qualifies. With `lk_valid` low, `hit`, `miss` and `violation` are all low.
- R3: On a hit, `pa_out` equals the matching entry's frame number in bits PA_W-1:12 and `lk_vaddr[11:0]` in bits 11:0. Without a hit, `pa_out` is zero.
- R4: `fill_perm` = 0 stores an entry as read only and 1 stores it as read/write. `violation` is high exactly when a write (`lk_write` = 1) hits a read-only entry. A read never violates, and a write to a read/write entry never violates.
- R5: A permitted hit sets the entry's use bit at the clock edge. A violating access leaves it unchanged. `hit_ref` shows the use bit of the hit entry as it stood before the current access.
- R6: A permitted write hit also sets the entry's modified bit. A read or a violating write leaves it unchanged. `hit_dirty` shows the modified bit of the hit entry before the current access.
- R7: `fill_en` writes the page number, identifier, frame number and permission into entry `fill_idx` in one cycle, marks it valid, and clears its use and modified bits, even when they were set before.
- R8: `flush` invalidates every entry at the clock edge. When `flush` and `fill_en` are high in the same cycle, flush wins and the refilled slot stays invalid.
- R9: If more than one valid entry matches, the lowest-numbered entry supplies the frame number, permission and status bits.
- R10: When a refill targets the entry that a lookup hits in the same cycle, the lookup still reports that entry's old contents. The refill wins, so the entry holds the new fields with its use and modified bits clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_asid | input | ASID_W | Address-space identifier of the request |
| lk_write | input | 1 | 1 = write access, 0 = read |
| fill_en | input | 1 | Refill strobe |
| fill_idx | input | IDX_W | Entry to overwrite |
| fill_vpn | input | VA_W-12 | Virtual page number to store |
| fill_asid | input | ASID_W | Identifier to store |
| fill_pfn | input | PA_W-12 | Physical frame number to store |
| fill_perm | input | 1 | 0 = read only, 1 = read/write |
| pa_out | output | PA_W | Translated physical address |
| hit | output | 1 | Lookup matched an entry |
| miss | output | 1 | Lookup matched no entry |
| violation | output | 1 | Write to a read-only page |
| hit_ref | output | 1 | Use bit of the hit entry before this access |
| hit_dirty | output | 1 | Modified bit of the hit entry before this access |

## Verification
A wrong valid bit shows up on the very next lookup to that page: a stale translation that should have been flushed, or a false miss. A wrong tag, identifier or frame field shows up as a wrong `pa_out` bit or a wrong hit/miss flag. A status bit that is set wrongly, or never set, stays hidden until the same page is looked up again. It then shows on `hit_ref` or `hit_dirty` one cycle or more after the access that caused it. The sweeps therefore visit every entry twice, with every identifier and both access kinds, so that each status update is read back on a later pass.

// File: rtl/xlat_pkg.sv
// Shared definitions for the translation buffer.
// Assumes: permission is a single bit, read-only versus read/write.
package xlat_pkg;
    typedef enum logic {
        ACC_RD_ONLY = 1'b0,
        ACC_RD_WR   = 1'b1
    } acc_perm_e;

    // True when a write to a page with this permission may complete.
    function automatic logic write_allowed(input acc_perm_e p);
        return (p == ACC_RD_WR);
    endfunction
endpackage

// File: rtl/xlat_entry.sv
// One translation slot: storage plus its own tag comparator.
// Assumes: flush outranks refill, which outranks a status update.
module xlat_entry
    import xlat_pkg::*;
#(
    parameter int VPN_W  = 20,
    parameter int PFN_W  = 20,
    parameter int ASID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              fill_we,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  acc_perm_e         fill_perm,
    input  logic [VPN_W-1:0]  look_vpn,
    input  logic [ASID_W-1:0] look_asid,
    input  logic              touch,
    input  logic              mark_dirty,
    output logic              match,
    output logic [PFN_W-1:0]  e_pfn,
    output acc_perm_e         e_perm,
    output logic              e_ref,
    output logic              e_dirty
);
    logic              valid_q;
    logic [VPN_W-1:0]  vpn_q;
    logic [ASID_W-1:0] asid_q;

    // Valid bit: cleared by reset or flush, set by refill.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) valid_q <= 1'b0;
        else if (fill_we)    valid_q <= 1'b1;
    end

    // Translation fields: loaded whole by a refill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q  <= '0;
            asid_q <= '0;
            e_pfn  <= '0;
            e_perm <= ACC_RD_ONLY;
        end else if (fill_we && !flush) begin
            vpn_q  <= fill_vpn;
            asid_q <= fill_asid;
            e_pfn  <= fill_pfn;
            e_perm <= fill_perm;
        end
    end

    // Status bits: cleared by refill, set by permitted accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_ref   <= 1'b0;
            e_dirty <= 1'b0;
        end else if (fill_we && !flush) begin
            e_ref   <= 1'b0;
            e_dirty <= 1'b0;
        end else begin
            if (touch)      e_ref   <= 1'b1;
            if (mark_dirty) e_dirty <= 1'b1;
        end
    end

    // Parallel comparison against the presented page and identifier.
    always_comb match = valid_q && (vpn_q == look_vpn) && (asid_q == look_asid);
endmodule

// File: rtl/xlat_prio_sel.sv
// Reduces a match vector to a one-hot grant, the lowest index winning.
// Assumes: N >= 1.
module xlat_prio_sel #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    // Keep only the lowest set request bit.
    always_comb begin
        logic seen;
        seen  = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !seen) begin
                grant[i] = 1'b1;
                seen     = 1'b1;
            end
        end
        any = seen;
    end
endmodule

// File: rtl/xlat_buffer.sv
// Fully associative page translation buffer with protection and use/modified
// tracking. Lookup results are combinational; status updates, refills and
// flushes take effect at the clock edge.
// Assumes: pages of 2**PAGE_BITS bytes, ENTRIES >= 2.
module xlat_buffer
    import xlat_pkg::*;
#(
    parameter int ENTRIES   = 8,
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int ASID_W    = 8,
    parameter int PAGE_BITS = 12,
    localparam int VPN_W    = VA_W - PAGE_BITS,
    localparam int PFN_W    = PA_W - PAGE_BITS,
    localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_write,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic              fill_perm,
    output logic [PA_W-1:0]   pa_out,
    output logic              hit,
    output logic              miss,
    output logic              violation,
    output logic              hit_ref,
    output logic              hit_dirty
);
    logic [VPN_W-1:0]   look_vpn;
    logic [ENTRIES-1:0] match_vec;
    logic [ENTRIES-1:0] grant_vec;
    logic               any_match;
    logic [PFN_W-1:0]   pfn_arr [ENTRIES];
    acc_perm_e          perm_arr [ENTRIES];
    logic [ENTRIES-1:0] ref_vec;
    logic [ENTRIES-1:0] dirty_vec;
    logic [PFN_W-1:0]   sel_pfn;
    acc_perm_e          sel_perm;
    logic               sel_ref;
    logic               sel_dirty;
    logic               allowed;
    acc_perm_e          fill_perm_e;

    // Split the page number off the incoming address.
    always_comb look_vpn = lk_vaddr[VA_W-1:PAGE_BITS];
    // Map the refill permission bit onto the shared type.
    always_comb fill_perm_e = fill_perm ? ACC_RD_WR : ACC_RD_ONLY;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        logic we;
        logic touch;
        logic mdirty;
        // Slot-local strobes: refill decode and status updates.
        always_comb begin
            we     = fill_en && (fill_idx == IDX_W'(i));
            touch  = grant_vec[i] && allowed;
            mdirty = grant_vec[i] && allowed && lk_write;
        end

        xlat_entry #(
            .VPN_W  (VPN_W),
            .PFN_W  (PFN_W),
            .ASID_W (ASID_W)
        ) u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .flush      (flush),
            .fill_we    (we),
            .fill_vpn   (fill_vpn),
            .fill_asid  (fill_asid),
            .fill_pfn   (fill_pfn),
            .fill_perm  (fill_perm_e),
            .look_vpn   (look_vpn),
            .look_asid  (lk_asid),
            .touch      (touch),
            .mark_dirty (mdirty),
            .match      (match_vec[i]),
            .e_pfn      (pfn_arr[i]),
            .e_perm     (perm_arr[i]),
            .e_ref      (ref_vec[i]),
            .e_dirty    (dirty_vec[i])
        );
    end

    xlat_prio_sel #(
        .N (ENTRIES)
    ) u_sel (
        .req   (match_vec),
        .grant (grant_vec),
        .any   (any_match)
    );

    // AND-OR multiplexer driven by the one-hot grant.
    always_comb begin
        sel_pfn   = '0;
        sel_perm  = ACC_RD_ONLY;
        sel_ref   = 1'b0;
        sel_dirty = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (grant_vec[i]) begin
                sel_pfn   = sel_pfn | pfn_arr[i];
                sel_perm  = perm_arr[i];
                sel_ref   = sel_ref | ref_vec[i];
                sel_dirty = sel_dirty | dirty_vec[i];
            end
        end
    end

    // Result flags and protection decision.
    always_comb begin
        hit       = lk_valid && any_match;
        miss      = lk_valid && !any_match;
        violation = hit && lk_write && !write_allowed(sel_perm);
        allowed   = hit && !violation;
        hit_ref   = hit && sel_ref;
        hit_dirty = hit && sel_dirty;
    end

    // Physical address: frame number joined to the untranslated offset.
    always_comb begin
        if (hit) pa_out = {sel_pfn, lk_vaddr[PAGE_BITS-1:0]};
        else     pa_out = '0;
    end
endmodule

// File: rtl/xlat_buffer_chk.sv
// Port-level property checker for xlat_buffer, attached by bind.
module xlat_buffer_chk #(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            flush,
    input logic            lk_valid,
    input logic [VA_W-1:0] lk_vaddr,
    input logic            lk_write,
    input logic [PA_W-1:0] pa_out,
    input logic            hit,
    input logic            miss,
    input logic            violation
);
    assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !hit);

    assert_hit_miss_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && miss));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(hit || miss || violation));

    assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (pa_out[PAGE_BITS-1:0] == lk_vaddr[PAGE_BITS-1:0]));

    assert_miss_pa_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (pa_out == '0));

    assert_viol_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        violation |-> (hit && lk_write));

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !hit);
endmodule

bind xlat_buffer xlat_buffer_chk #(
    .VA_W      (VA_W),
    .PA_W      (PA_W),
    .PAGE_BITS (PAGE_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .lk_valid  (lk_valid),
    .lk_vaddr  (lk_vaddr),
    .lk_write  (lk_write),
    .pa_out    (pa_out),
    .hit       (hit),
    .miss      (miss),
    .violation (violation)
);

// File: tb/xlat_buffer_tb.sv
`timescale 1ns/1ps
module xlat_buffer_tb;
    localparam int N   = 4;
    localparam int VAW = 20;
    localparam int PAW = 24;
    localparam int ASW = 4;

    logic clk = 0, rst_n = 0, flush = 0;
    logic lk_valid = 0, lk_write = 0, fill_en = 0, fill_perm = 0;
    logic [VAW-1:0] lk_vaddr = '0;
    logic [ASW-1:0] lk_asid = '0, fill_asid = '0;
    logic [1:0]     fill_idx = '0;
    logic [7:0]     fill_vpn = '0;
    logic [11:0]    fill_pfn = '0;
    logic [PAW-1:0] pa_out;
    logic hit, miss, violation, hit_ref, hit_dirty;

    int checks = 0, fails = 0;
    bit done = 0;

    // Bench model of the entries.
    bit         m_v [N];
    logic [7:0] m_vpn [N];
    logic [3:0] m_as [N];
    logic [11:0] m_pfn [N];
    bit         m_rw [N], m_ref [N], m_dty [N];

    xlat_buffer #(.ENTRIES(N), .VA_W(VAW), .PA_W(PAW), .ASID_W(ASW)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid),
        .lk_vaddr(lk_vaddr), .lk_asid(lk_asid), .lk_write(lk_write),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_vpn(fill_vpn),
        .fill_asid(fill_asid), .fill_pfn(fill_pfn), .fill_perm(fill_perm),
        .pa_out(pa_out), .hit(hit), .miss(miss), .violation(violation),
        .hit_ref(hit_ref), .hit_dirty(hit_dirty));

    always #2 clk = ~clk;

    // One cycle: drive at negedge, check before the edge, update model after.
    task automatic step(input bit lv, input logic [19:0] va, input logic [3:0] as,
                        input bit wr, input bit fe, input int fi, input logic [7:0] fv,
                        input logic [3:0] fa, input logic [11:0] fp, input bit fperm,
                        input bit fl, input string tag);
        int w;
        logic [28:0] exp_v, act_v;
        bit viol;
        @(negedge clk);
        lk_valid = lv; lk_vaddr = va; lk_asid = as; lk_write = wr;
        fill_en = fe; fill_idx = fi[1:0]; fill_vpn = fv; fill_asid = fa;
        fill_pfn = fp; fill_perm = fperm; flush = fl;
        #1;
        w = -1;
        for (int j = N - 1; j >= 0; j--)
            if (m_v[j] && m_vpn[j] == va[19:12] && m_as[j] == as) w = j;
        viol = lv && (w >= 0) && wr && !m_rw[w];
        if (lv && w >= 0)
            exp_v = {1'b1, 1'b0, viol, m_ref[w], m_dty[w], m_pfn[w], va[11:0]};
        else
            exp_v = {1'b0, lv, 1'b0, 2'b00, 24'h0};
        act_v = {hit, miss, violation, hit_ref, hit_dirty, pa_out};
        checks++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s: {hit,miss,viol,ref,dirty,pa} actual %h expected %h", tag, act_v, exp_v);
        end
        @(posedge clk);
        if (fl) begin
            for (int j = 0; j < N; j++) m_v[j] = 0;
        end else begin
            if (lv && w >= 0 && !viol && !(fe && fi == w)) begin
                m_ref[w] = 1;
                if (wr) m_dty[w] = 1;
            end
            if (fe) begin
                m_v[fi] = 1; m_vpn[fi] = fv; m_as[fi] = fa; m_pfn[fi] = fp;
                m_rw[fi] = fperm; m_ref[fi] = 0; m_dty[fi] = 0;
            end
        end
    endtask

    task automatic look(input logic [19:0] va, input logic [3:0] as, input bit wr, input string tag);
        step(1, va, as, wr, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic fill(input int fi, input logic [7:0] fv, input logic [3:0] fa,
                        input logic [11:0] fp, input bit fperm);
        step(0, 0, 0, 0, 1, fi, fv, fa, fp, fperm, 0, "R7 fill idle R2");
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        for (int j = 0; j < N; j++) begin
            m_v[j] = 0; m_ref[j] = 0; m_dty[j] = 0; m_rw[j] = 0;
            m_vpn[j] = 0; m_as[j] = 0; m_pfn[j] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: empty after reset, every page misses.
        for (int v = 0; v < 8; v++) look({8'(v), 12'h5A0}, 4'(v % 2), v[0], "R1 empty");
        // R2: idle lookup port is quiet.
        step(0, 20'h11000, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R2 idle");
        // R7: load all slots; slot 3 shares a page number with slot 0 under another identifier.
        fill(0, 8'h11, 4'd1, 12'hA01, 1);
        fill(1, 8'h22, 4'd1, 12'hB02, 0);
        fill(2, 8'h33, 4'd2, 12'hC03, 1);
        fill(3, 8'h11, 4'd2, 12'hD04, 0);
        // R2 R3 R4 R5 R6: sweep pages x identifiers x access kinds, twice.
        for (int p = 0; p < 2; p++)
            for (int e = 0; e < 5; e++)
                for (int a = 0; a < 4; a++)
                    for (int wr = 0; wr < 2; wr++) begin
                        logic [7:0] vp;
                        vp = (e == 4) ? 8'h44 : ((e == 3) ? 8'h11 : 8'(8'h11 * (e + 1)));
                        look({vp, 12'(e * 12'h123 + a * 12'h40 + wr)}, 4'(a), wr[0], "R2 R3 R4 R5 R6 sweep");
                    end
        // R9: duplicate of slot 1 in slot 3; slot 1 (read only) must win.
        fill(3, 8'h22, 4'd1, 12'hEEE, 1);
        look(20'h22FFF, 1, 1, "R9 lowest index");
        look(20'h22001, 1, 0, "R9 lowest index read");
        // R7: refill a slot whose status bits are set; they must read back clear.
        fill(0, 8'h11, 4'd1, 12'h777, 0);
        look(20'h11ABC, 1, 0, "R7 status cleared");
        look(20'h11ABC, 1, 1, "R7 new permission");
        // R10: write hit on slot 2 while slot 2 is refilled.
        step(1, 20'h33010, 2, 1, 1, 2, 8'h55, 4'd3, 12'h321, 1, 0, "R10 old contents");
        look(20'h33010, 2, 0, "R10 old page gone");
        look(20'h55010, 3, 0, "R10 new fields clear");
        // R8: flush together with a refill; everything misses afterwards.
        step(0, 0, 0, 0, 1, 1, 8'h66, 4'd0, 12'h999, 1, 1, "R8 flush");
        look(20'h66000, 0, 0, "R8 refill lost");
        look(20'h55010, 3, 0, "R8 flushed");
        look(20'h22000, 1, 0, "R8 flushed");
        done = 1;
        finish_run();
    end

    initial begin
        #800000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end
endmodule